// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces the column address for every beat of a single read or write burst to a DDR2 memory. A controller supplies a starting column, a burst length of 4 or 8 and an ordering choice (sequential or interleaved), then pulses a start strobe. From the next cycle the block presents one column address per clock with a valid flag. A last flag marks the final beat.

The columns of a burst all lie in an aligned block whose size equals the burst length. The upper column bits come from the start address and stay fixed for the whole burst. Only the low bits move, and they wrap inside the block. With sequential ordering and a burst of 8, the low two bits count modulo 4 and the third bit flips halfway through, so each 4-column half wraps on its own. Interleaved ordering XORs the beat number into the start offset.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start strobe, colValid and colLast are low.
- R2: A start strobe sampled while colValid is low starts a burst. colValid rises on the next cycle and the first colOut equals startCol.
- R3: colValid stays high for exactly 4 consecutive cycles when blSel was 0 at start, or exactly 8 when it was 1. colLast is high only on the final of these cycles.
- R4: Throughout a burst, colOut bits COL_W-1..2 equal those of startCol for a burst of 4. For a burst of 8, bits COL_W-1..3 equal those of startCol.
- R5: For a burst of 4 with sequential ordering (interleaveSel 0), colOut[1:0] on beat i (counting from 0) is (startCol[1:0] + i) mod 4.
- R6: For a burst of 8 with sequential ordering, colOut[1:0] on beat i is (startCol[1:0] + i) mod 4, and colOut[2] is startCol[2] XOR (i >= 4). For example, start offset 1 gives 1,2,3,0,5,6,7,4.
- R7: With interleaved ordering (interleaveSel 1), the low offset bits on beat i are the start offset XOR i: bits [1:0] for a burst of 4, bits [2:0] for a burst of 8.
- R8: blSel (0 selects a burst of 4, 1 a burst of 8) and interleaveSel (0 sequential, 1 interleaved) are sampled with the accepted start strobe. Changing them during a burst has no effect on that burst.
- R9: A start strobe sampled while colValid is high is ignored, including on the last beat. colValid goes low for at least one cycle after colLast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start request for a new burst |
| startCol | input | COL_W | Starting column address |
| blSel | input | 1 | Burst length: 0 for 4 beats, 1 for 8 beats |
| interleaveSel | input | 1 | Ordering: 0 for sequential, 1 for interleaved |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | High on each beat of a burst |
| colLast | output | 1 | High on the final beat of a burst |

## Verification
The bench builds the block with COL_W set to 6. This makes the column space small enough to sweep every starting column in all four length and ordering combinations. So every wrap point, every start offset and every value of the held upper bits is covered. Further bursts keep the start strobe high and toggle the length and ordering inputs on every beat. These reach the ignore rules on the final beat and the sampling of the mode inputs.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Beat index width covers the longest burst (8 beats).
  localparam int BEAT_W = 3;
  localparam int OFFS_W = 3;

  typedef struct packed {
    logic load;   // accept a new burst
    logic step;   // advance to the next beat
    logic stop;   // final beat, return to idle
  } seqCtrl_t;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              blSel,
  output seqCtrl_t          ctrl,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              busy,
  output logic              lastBeat
);
  localparam logic [BEAT_W-1:0] LAST4 = BEAT_W'(3);
  localparam logic [BEAT_W-1:0] LAST8 = BEAT_W'(7);

  logic bl8Q;

  // Final beat depends on the length latched at start (R3, R8).
  always_comb begin
    lastBeat = busy && (beatIdx == (bl8Q ? LAST8 : LAST4));
  end

  // Start strobes while busy are not accepted (R9).
  always_comb begin
    ctrl.load = startStb && !busy;
    ctrl.step = busy && !lastBeat;
    ctrl.stop = lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beatIdx <= '0;
      bl8Q    <= 1'b0;
    end else if (ctrl.load) begin
      busy    <= 1'b1;
      beatIdx <= '0;
      bl8Q    <= blSel;
    end else if (ctrl.step) begin
      beatIdx <= beatIdx + 1'b1;
    end else if (ctrl.stop) begin
      busy    <= 1'b0;
      beatIdx <= '0;
    end
  end
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [COL_W-1:0]  startCol,
  input  logic              blSel,
  input  logic              interleaveSel,
  input  logic [BEAT_W-1:0] beatIdx,
  output logic [COL_W-1:0]  colOut
);
  logic [COL_W-1:0]  baseQ;
  logic              bl8Q;
  logic              ilvQ;
  logic [OFFS_W-1:0] startOff;
  logic [OFFS_W-1:0] seqOff;
  logic [OFFS_W-1:0] ilvOff;
  logic [OFFS_W-1:0] pickOff;

  // Latch address and mode with the accepted start (R8).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      bl8Q  <= 1'b0;
      ilvQ  <= 1'b0;
    end else if (ctrl.load) begin
      baseQ <= startCol;
      bl8Q  <= blSel;
      ilvQ  <= interleaveSel;
    end
  end

  assign startOff = baseQ[OFFS_W-1:0];

  // Sequential: low pair counts modulo 4, bit 2 flips on the second half.
  always_comb begin
    seqOff[1:0] = startOff[1:0] + beatIdx[1:0];
    seqOff[2]   = startOff[2] ^ beatIdx[2];
  end

  // Interleaved: XOR of beat number into the offset.
  assign ilvOff  = startOff ^ beatIdx;
  assign pickOff = ilvQ ? ilvOff : seqOff;

  // Block bits above the burst size are held from the start column.
  always_comb begin
    colOut = baseQ;
    if (bl8Q) colOut[2:0] = pickOff;
    else      colOut[1:0] = pickOff[1:0];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic             blSel,
  input  logic             interleaveSel,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast
);
  seqCtrl_t          ctrl;
  logic [BEAT_W-1:0] beatIdx;
  logic              busy;
  logic              lastBeat;

  bcs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .blSel    (blSel),
    .ctrl     (ctrl),
    .beatIdx  (beatIdx),
    .busy     (busy),
    .lastBeat (lastBeat)
  );

  bcs_datapath #(.COL_W(COL_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .startCol      (startCol),
    .blSel         (blSel),
    .interleaveSel (interleaveSel),
    .beatIdx       (beatIdx),
    .colOut        (colOut)
  );

  assign colValid = busy;
  assign colLast  = lastBeat;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic             blSel,
  input logic             interleaveSel,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             colLast
);
  logic [2:0]       runCnt;
  logic             capBl8;
  logic             capIlv;
  logic [2:0]       capOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
      capBl8 <= 1'b0;
      capIlv <= 1'b0;
      capOff <= '0;
    end else if (startStb && !colValid) begin
      runCnt <= '0;
      capBl8 <= blSel;
      capIlv <= interleaveSel;
      capOff <= startCol[2:0];
    end else if (colValid && !colLast) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  AST_LAST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> (runCnt == (capBl8 ? 3'd7 : 3'd3))); // R3
  AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid); // R3
  AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast) |=> colValid); // R3
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    colLast |=> !colValid); // R9
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colValid) |-> $past(startStb)); // R2
  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colValid) |-> (colOut == $past(startCol))); // R2
  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colLast) |=> (colOut[COL_W-1:3] == $past(colOut[COL_W-1:3]))); // R4
  AST_ILV_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && capIlv && capBl8) |-> (colOut[2:0] == (capOff ^ runCnt))); // R7
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 6;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             blSel = 1'b0;
  logic             interleaveSel = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             colLast;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk; // 50 MHz

  burst_col_seq #(.COL_W(COL_W)) u_dut (.*);

  function automatic logic [COL_W-1:0] expCol(int s, bit bl8, bit ilv, int i);
    int blk = bl8 ? 8 : 4;
    int off = s % blk;
    int base = s - off;
    int o;
    if (ilv) o = off ^ i;
    else if (!bl8) o = (off + i) % 4;
    else o = (((off / 4) ^ (i / 4)) * 4) + ((off % 4 + i % 4) % 4);
    return COL_W'(base + o);
  endfunction

  // Driver: start a burst and queue its expected beats.
  task automatic runBurst(int s, bit bl8, bit ilv, bit holdStart);
    int len = bl8 ? 8 : 4;
    string tg;
    tg = ilv ? "R7" : (bl8 ? "R6" : "R5");
    if (holdStart) tg = {tg, "/R8/R9"};
    @(negedge clk);
    startStb = 1'b1;
    startCol = COL_W'(s);
    blSel = bl8;
    interleaveSel = ilv;
    for (int i = 0; i < len; i++) begin
      expItem_t it;
      it.col = expCol(s, bl8, ilv, i);
      it.last = (i == len - 1);
      it.tag = (i == 0) ? {"R2/R4/", tg} : {"R4/", tg};
      expQ.push_back(it);
    end
    if (!holdStart) begin
      @(negedge clk);
      startStb = 1'b0;
      repeat (len - 1) @(negedge clk);
    end else begin
      // Keep requesting with other values through the last beat.
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        startStb = 1'b1;
        startCol = ~COL_W'(s + i);
        blSel = ~bl8;
        interleaveSel = ~ilv;
      end
      @(negedge clk);
      startStb = 1'b0;
    end
  endtask

  // Monitor: compare each produced beat against the scoreboard.
  always @(negedge clk) begin
    if (monOn) begin
      if (colValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected beat col=%0d, expected no valid", colOut);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (colOut !== it.col) begin
            errors++;
            $display("FAIL %s: col actual=%0d expected=%0d", it.tag, colOut, it.col);
          end
          checks++;
          if (colLast !== it.last) begin
            errors++;
            $display("FAIL R3: last actual=%0b expected=%0b", colLast, it.last);
          end
        end
      end else if (colLast) begin
        checks++;
        errors++;
        $display("FAIL R3: last actual=1 expected=0 while not valid");
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (colValid !== 1'b0 || colLast !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset valid=%0b last=%0b expected 0 0", colValid, colLast);
    end
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (colValid !== 1'b0 || colLast !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset valid=%0b last=%0b expected 0 0", colValid, colLast);
    end
    monOn = 1'b1;

    // Sweep all start columns in every length/ordering combination (R5, R6, R7).
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < (1 << COL_W); s++) begin
        runBurst(s, m[1], m[0], 1'b0);
      end
    end
    // Held start strobe and toggling mode inputs during bursts (R8, R9).
    runBurst(1, 1'b1, 1'b0, 1'b1);
    runBurst(6, 1'b0, 1'b1, 1'b1);
    runBurst(45, 1'b1, 1'b1, 1'b1);
    runBurst(30, 1'b0, 1'b0, 1'b1);

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3: beats missing actual=0 expected=%0d", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule